// File: doc/BRIEF.md
# Continuous Two-Byte Program Controller

This block runs the continuous-program mode of a serial flash command decoder. A serial front end hands it decoded bytes together with chip-select falling and rising edge strobes. When software issues the continuous-program opcode (AD hex), the first frame carries a 24-bit address followed by two data bytes. Once that frame is accepted, the controller asks a behavioural memory array to write both bytes to an aligned even/odd address pair. It then enters the continuous-program mode. Each later frame carries only the opcode and two data bytes, and it targets the next pair, because the internal pointer advances by two after every finished cycle.

While the mode is active, the controller accepts only a small set of opcodes. It leaves the mode when a write-disable arrives with no write in progress, or when the pair just finished was the last one that fits below the protection limit or at the top of the address space. The address never wraps. Opcodes that belong to other parts of the chip (status reads and similar) are forwarded on a one-cycle pass strobe, and only when the filter allows them.

Top module: `cp_prog_ctrl`

## Requirements
- R1: After reset, `wip`, `wel`, `cp_mode`, `prog_req` and `op_pass` are all 0.
- R2: A frame holding only opcode 06 hex, sent outside the mode, sets `wel` at chip-select rise. A program frame sent while `wel` is 0 starts nothing.
- R3: An entry frame is opcode AD hex, three address bytes (most significant first) and two data bytes. At chip-select rise the block issues a single-cycle `prog_req` with `prog_addr` set to the address with bit 0 cleared, `prog_byte0` set to the first data byte (for the even address) and `prog_byte1` set to the second (for the odd address). It also sets `cp_mode`.
- R4: A program frame with fewer than two data bytes starts nothing. Data bytes after the second are ignored.
- R5: If the odd address of the target pair is above `unprot_top`, the program frame is ignored, and `wel` and `cp_mode` are unchanged.
- R6: `wip` rises together with `prog_req` and stays 1 until the cycle after `prog_done` is seen. A program frame that ends while `wip` is 1 is rejected.
- R7: While in the mode, a frame of opcode AD hex plus two data bytes programs the pair two addresses above the previous pair.
- R8: The mode ends by itself when a cycle finishes and the next pair (pointer+2, pointer+3) would either exceed `unprot_top` or pass the highest address. At that point `cp_mode` and `wel` both clear in the same cycle that `wip` clears.
- R9: While in the mode, only AD, 04, 05, A1 and 2B hex are accepted, and every other opcode is ignored. `op_pass` pulses one cycle after the opcode byte for 05, A1 and 2B while in the mode, and outside the mode for every opcode except AD, 04 and 06. `op_code` holds that opcode.
- R10: Opcode 04 hex ends the mode and clears `wel` only when `wip` is 0. While `wip` is 1 it is ignored. Outside the mode it clears `wel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_fall | input | 1 | Chip select went low: a new frame starts |
| cs_rise | input | 1 | Chip select went high: the frame ends and is executed |
| rx_valid | input | 1 | A decoded byte is present on `rx_byte` |
| rx_byte | input | 8 | Decoded serial byte |
| unprot_top | input | AW | Highest address that may be programmed |
| prog_done | input | 1 | The array has finished the current two-byte cycle |
| prog_req | output | 1 | One-cycle request to program a pair |
| prog_addr | output | AW | Even address of the pair |
| prog_byte0 | output | 8 | Byte for the even address |
| prog_byte1 | output | 8 | Byte for the odd address |
| wip | output | 1 | A program cycle is in progress |
| wel | output | 1 | Write enable latch |
| cp_mode | output | 1 | Continuous-program mode is active |
| op_pass | output | 1 | The opcode on `op_code` is forwarded to other logic |
| op_code | output | 8 | Forwarded opcode |

## Verification
The bench targets the following corner cases, and each one exposes a specific kind of bug:
- **Odd start address:** a controller that forgets to force the address even programs the pair off by one.
- **One-byte frames and three-byte frames:** a controller that miscounts data bytes either programs a lone byte or takes the third byte.
- **Frames sent during a write** (a program frame, a write-disable and a disallowed write-enable): a controller that handles these wrongly corrupts the pair in flight, or drops out of the mode early.
- **Exit at a protection limit and at the very top of the address space:** a controller without the no-wrap rule stays in the mode and later writes to address zero.

// File: rtl/cp_pkg.sv
package cp_pkg;
    localparam logic [7:0] OPC_CPROG  = 8'hAD;
    localparam logic [7:0] OPC_WRDIS  = 8'h04;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_STAT   = 8'h05;
    localparam logic [7:0] OPC_PROTRD = 8'hA1;
    localparam logic [7:0] OPC_SECRD  = 8'h2B;
    localparam int         ADDR_BYTES = 3;
    localparam int         ABUF_BITS  = 8 * ADDR_BYTES;
endpackage

// File: rtl/cp_op_filter.sv
module cp_op_filter
    import cp_pkg::*;
(
    input  logic [7:0] op,
    input  logic       in_mode,
    output logic       allowed,
    output logic       pass
);
    logic is_read;
    logic is_listed;
    logic is_local;

    always_comb begin
        is_read   = (op == OPC_STAT) || (op == OPC_PROTRD) || (op == OPC_SECRD);
        is_listed = is_read || (op == OPC_CPROG) || (op == OPC_WRDIS);
        is_local  = (op == OPC_CPROG) || (op == OPC_WRDIS) || (op == OPC_WREN);
        allowed   = !in_mode || is_listed;
        pass      = in_mode ? is_read : !is_local;
    end
endmodule

// File: rtl/cp_frame_rx.sv
module cp_frame_rx
    import cp_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          cur_mode,
    output logic [2:0]    nbytes,
    output logic [7:0]    opcode,
    output logic          frame_mode,
    output logic [AW-1:0] addr,
    output logic [7:0]    dat0,
    output logic [7:0]    dat1
);
    typedef struct packed {
        logic [2:0]           cnt;
        logic [7:0]           op;
        logic                 fmode;
        logic [ABUF_BITS-1:0] abuf;
        logic [7:0]           d0;
        logic [7:0]           d1;
    } rx_state_t;

    rx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cs_fall) begin
            s_d.cnt = '0;
        end else if (rx_valid) begin
            if (s_q.cnt != 3'd7) s_d.cnt = s_q.cnt + 3'd1;
            if (s_q.cnt == 3'd0) begin
                s_d.op    = rx_byte;
                s_d.fmode = cur_mode;
            end else if (s_q.fmode) begin
                if (s_q.cnt == 3'd1) s_d.d0 = rx_byte;
                if (s_q.cnt == 3'd2) s_d.d1 = rx_byte;
            end else begin
                if (s_q.cnt <= 3'd3) s_d.abuf = {s_q.abuf[ABUF_BITS-9:0], rx_byte};
                if (s_q.cnt == 3'd4) s_d.d0 = rx_byte;
                if (s_q.cnt == 3'd5) s_d.d1 = rx_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nbytes     = s_q.cnt;
    assign opcode     = s_q.op;
    assign frame_mode = s_q.fmode;
    assign addr       = s_q.abuf[AW-1:0];
    assign dat0       = s_q.d0;
    assign dat1       = s_q.d1;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (nbytes == 3'd0)); // R4
endmodule

// File: rtl/cp_prog_ctrl.sv
module cp_prog_ctrl
    import cp_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic [AW-1:0] unprot_top,
    input  logic          prog_done,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [7:0]    prog_byte0,
    output logic [7:0]    prog_byte1,
    output logic          wip,
    output logic          wel,
    output logic          cp_mode,
    output logic          op_pass,
    output logic [7:0]    op_code
);
    typedef struct packed {
        logic          wel;
        logic          wip;
        logic          mode;
        logic [AW-1:0] ptr;
        logic          req;
        logic [AW-1:0] paddr;
        logic [7:0]    pd0;
        logic [7:0]    pd1;
        logic          pass;
        logic [7:0]    pcode;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    logic [2:0]    f_nb;
    logic [7:0]    f_op;
    logic          f_mode;
    logic [AW-1:0] f_addr;
    logic [7:0]    f_d0;
    logic [7:0]    f_d1;
    logic          f_allowed;
    logic          f_pass_unused;
    logic          rx_allowed_unused;
    logic          rx_pass;
    logic          have_data;
    logic          target_prot;
    logic          last_pair;
    logic [AW-1:0] req_addr;
    logic [AW:0]   next_hi;

    cp_frame_rx #(.AW(AW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .cur_mode   (s_q.mode),
        .nbytes     (f_nb),
        .opcode     (f_op),
        .frame_mode (f_mode),
        .addr       (f_addr),
        .dat0       (f_d0),
        .dat1       (f_d1)
    );

    // filter applied when the frame executes, using the mode seen at its opcode
    cp_op_filter u_flt_exec (
        .op      (f_op),
        .in_mode (f_mode),
        .allowed (f_allowed),
        .pass    (f_pass_unused)
    );

    // filter applied to the opcode byte as it arrives, for forwarding
    cp_op_filter u_flt_rx (
        .op      (rx_byte),
        .in_mode (s_q.mode),
        .allowed (rx_allowed_unused),
        .pass    (rx_pass)
    );

    always_comb begin
        have_data   = f_mode ? (f_nb >= 3'd3) : (f_nb >= 3'd6);
        req_addr    = f_mode ? s_q.ptr : {f_addr[AW-1:1], 1'b0};
        target_prot = (req_addr | AW'(1)) > unprot_top;
        next_hi     = {1'b0, s_q.ptr} + (AW+1)'(3);
        last_pair   = next_hi > {1'b0, unprot_top};
    end

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.pass = 1'b0;

        if (rx_valid && !cs_fall && (f_nb == 3'd0)) begin
            s_d.pass  = rx_pass;
            s_d.pcode = rx_byte;
        end

        if (prog_done && s_q.wip) begin
            s_d.wip = 1'b0;
            s_d.ptr = s_q.ptr + AW'(2);
            if (last_pair) begin
                s_d.mode = 1'b0;
                s_d.wel  = 1'b0;
            end
        end

        if (cs_rise && (f_nb != 3'd0) && f_allowed) begin
            case (f_op)
                OPC_WREN: begin
                    if (!s_q.mode) s_d.wel = 1'b1;
                end
                OPC_WRDIS: begin
                    if (!s_q.mode) begin
                        s_d.wel = 1'b0;
                    end else if (!s_q.wip) begin
                        s_d.mode = 1'b0;
                        s_d.wel  = 1'b0;
                    end
                end
                OPC_CPROG: begin
                    if (have_data && s_q.wel && !s_q.wip &&
                        (f_mode == s_q.mode) && !target_prot) begin
                        s_d.req   = 1'b1;
                        s_d.wip   = 1'b1;
                        s_d.mode  = 1'b1;
                        s_d.ptr   = req_addr;
                        s_d.paddr = req_addr;
                        s_d.pd0   = f_d0;
                        s_d.pd1   = f_d1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prog_req   = s_q.req;
    assign prog_addr  = s_q.paddr;
    assign prog_byte0 = s_q.pd0;
    assign prog_byte1 = s_q.pd1;
    assign wip        = s_q.wip;
    assign wel        = s_q.wel;
    assign cp_mode    = s_q.mode;
    assign op_pass    = s_q.pass;
    assign op_code    = s_q.pcode;

    AST_REQ_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !prog_addr[0]); // R3
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (wel && wip && cp_mode)); // R2
    AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !$past(wip)); // R6
    AST_WIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !prog_done) |=> wip); // R6
    AST_MODE_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        cp_mode |-> wel); // R8
    AST_EXIT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && wip && last_pair) |=> (!cp_mode && !wel)); // R8
    AST_WRDIS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !prog_done) |=> cp_mode); // R10
endmodule

// File: tb/cp_prog_ctrl_tb.sv
module cp_prog_ctrl_tb;
    localparam int AW  = 24;
    localparam int LAT = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_fall = 1'b0, cs_rise = 1'b0, rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic [AW-1:0] unprot_top = 24'h0000FF;
    logic          prog_done = 1'b0;
    logic          prog_req, wip, wel, cp_mode, op_pass;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_byte0, prog_byte1, op_code;

    int checks = 0, errors = 0, npass = 0, busy = 0;
    bit done_flag = 0;
    logic [7:0] mem [int];

    always #2.5 clk = ~clk;

    cp_prog_ctrl #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .unprot_top(unprot_top),
        .prog_done(prog_done), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_byte0(prog_byte0), .prog_byte1(prog_byte1), .wip(wip), .wel(wel),
        .cp_mode(cp_mode), .op_pass(op_pass), .op_code(op_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int memrd(input int a);
        return mem.exists(a) ? int'(mem[a]) : 'hFF;
    endfunction

    // ---------------- behavioural reference model ----------------
    bit m_wel, m_wip, m_mode, m_req, m_pass, m_fmode;
    int m_ptr, m_paddr, m_d0, m_d1, m_pcode;
    logic [7:0] fq[$];

    function automatic bit is_rd(input logic [7:0] o);
        return o == 8'h05 || o == 8'hA1 || o == 8'h2B;
    endfunction
    function automatic bit listed(input logic [7:0] o);
        return is_rd(o) || o == 8'hAD || o == 8'h04;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        bit ow, owip, om;
        int hdr, a;
        if (!rst_n) begin
            m_wel = 0; m_wip = 0; m_mode = 0; m_req = 0; m_pass = 0; m_fmode = 0;
            m_ptr = 0; fq.delete();
        end else begin
            ow = m_wel; owip = m_wip; om = m_mode;
            m_req = 0; m_pass = 0;
            if (cs_fall) fq.delete();
            else if (rx_valid) begin
                if (fq.size() == 0) begin
                    m_fmode = om;
                    m_pass  = om ? is_rd(rx_byte)
                                 : !(rx_byte == 8'hAD || rx_byte == 8'h04 || rx_byte == 8'h06);
                    m_pcode = rx_byte;
                end
                if (fq.size() < 8) fq.push_back(rx_byte);
            end
            if (prog_done && owip) begin
                m_wip = 0;
                if (m_ptr + 3 > int'(unprot_top)) begin m_mode = 0; m_wel = 0; end
                m_ptr = (m_ptr + 2) & 'hFFFFFF;
            end
            if (cs_rise && fq.size() > 0 && (!m_fmode || listed(fq[0]))) begin
                if (fq[0] == 8'h06 && !om) m_wel = 1;
                if (fq[0] == 8'h04) begin
                    if (!om) m_wel = 0;
                    else if (!owip) begin m_mode = 0; m_wel = 0; end
                end
                if (fq[0] == 8'hAD) begin
                    hdr = m_fmode ? 1 : 4;
                    if (fq.size() >= hdr + 2 && ow && !owip && m_fmode == om) begin
                        a = m_fmode ? m_ptr : (int'({fq[1], fq[2], fq[3]}) & 'hFFFFFE);
                        if ((a | 1) <= int'(unprot_top)) begin
                            m_req = 1; m_wip = 1; m_mode = 1; m_ptr = a; m_paddr = a;
                            m_d0 = fq[hdr]; m_d1 = fq[hdr+1];
                        end
                    end
                end
            end
        end
    end

    // per-clock comparison and behavioural array
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 wip", wip, m_wip);
            chk("R2 wel", wel, m_wel);
            chk("R8 cp_mode", cp_mode, m_mode);
            chk("R3 prog_req", prog_req, m_req);
            if (m_req) begin
                chk("R3 prog_addr", prog_addr, m_paddr);
                chk("R3 byte0", prog_byte0, m_d0);
                chk("R3 byte1", prog_byte1, m_d1);
            end
            chk("R9 op_pass", op_pass, m_pass);
            if (m_pass) chk("R9 op_code", op_code, m_pcode);
            if (op_pass) npass++;
            prog_done = 0;
            if (busy > 0) begin
                busy--;
                if (busy == 0) prog_done = 1;
            end
            if (prog_req) begin
                mem[int'(prog_addr)]     = prog_byte0;
                mem[int'(prog_addr) + 1] = prog_byte1;
                busy = LAT;
            end
        end
    end

    task automatic frame(input int n, input logic [7:0] b0, b1 = 0, b2 = 0, b3 = 0,
                         b4 = 0, b5 = 0, b6 = 0);
        logic [7:0] b [7];
        b = '{b0, b1, b2, b3, b4, b5, b6};
        @(negedge clk); cs_fall = 1;
        @(negedge clk); cs_fall = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_byte = b[i];
            @(negedge clk);
        end
        rx_valid = 0;
        @(negedge clk); cs_rise = 1;
        @(negedge clk); cs_rise = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && wip; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        chk("R1 wip", wip, 0); chk("R1 wel", wel, 0); chk("R1 cp_mode", cp_mode, 0);
        chk("R1 prog_req", prog_req, 0); chk("R1 op_pass", op_pass, 0);
        rst_n = 1;
        // R2: no write enable yet
        frame(6, 8'hAD, 8'h00, 8'h00, 8'h10, 8'h11, 8'h22);
        chk("R2 no wel no program", memrd('h10), 'hFF);
        frame(1, 8'h06);
        chk("R2 wel set", wel, 1);
        // R5: protected pair
        frame(6, 8'hAD, 8'h00, 8'h02, 8'h00, 8'h31, 8'h32);
        chk("R5 mode", cp_mode, 0); chk("R5 wel kept", wel, 1);
        chk("R5 mem", memrd('h200), 'hFF);
        // R4: only one data byte
        frame(5, 8'hAD, 8'h00, 8'h00, 8'h20, 8'h55);
        chk("R4 one byte", cp_mode, 0); chk("R4 mem", memrd('h20), 'hFF);
        // R3 odd start, R4 third data byte ignored
        frame(7, 8'hAD, 8'h00, 8'h00, 8'h11, 8'hA1, 8'hB2, 8'hC3);
        chk("R6 wip high", wip, 1); chk("R3 mode on", cp_mode, 1);
        frame(3, 8'hAD, 8'h33, 8'h44);       // R6 rejected while busy
        frame(1, 8'h04);                     // R10 ignored while busy
        chk("R10 busy wrdis", cp_mode, 1);
        p0 = npass;
        frame(1, 8'h06);                     // R9 filtered
        frame(1, 8'h05);                     // R9 forwarded
        chk("R9 pass in mode", npass, p0 + 1);
        wait_idle();
        chk("R3 even byte", memrd('h10), 'hA1); chk("R3 odd byte", memrd('h11), 'hB2);
        chk("R4 extra ignored", memrd('h12), 'hFF);
        // R7 auto increment
        frame(3, 8'hAD, 8'h55, 8'h66);
        wait_idle();
        chk("R7 next even", memrd('h12), 'h55); chk("R7 next odd", memrd('h13), 'h66);
        p0 = npass;
        frame(1, 8'h02); frame(1, 8'hA1);
        chk("R9 filter", npass, p0 + 1);
        frame(1, 8'h04);
        chk("R10 exit mode", cp_mode, 0); chk("R10 wel clear", wel, 0);
        p0 = npass;
        frame(1, 8'h05); frame(1, 8'h02);
        chk("R9 outside", npass, p0 + 2);
        // R8 exit at protection limit
        frame(1, 8'h06);
        frame(6, 8'hAD, 8'h00, 8'h00, 8'hFD, 8'hE1, 8'hE2);
        wait_idle();
        chk("R8 still in", cp_mode, 1);
        frame(3, 8'hAD, 8'hE3, 8'hE4);
        wait_idle();
        chk("R8 exit mode", cp_mode, 0); chk("R8 exit wel", wel, 0);
        chk("R8 last byte", memrd('hFF), 'hE4);
        frame(3, 8'hAD, 8'hE5, 8'hE6);
        chk("R8 no wrap", memrd('h0), 'hFF);
        // R8 exit at the top of the address space
        unprot_top = 24'hFFFFFF;
        frame(1, 8'h06);
        frame(6, 8'hAD, 8'hFF, 8'hFF, 8'hFE, 8'h71, 8'h72);
        wait_idle();
        chk("R8 top exit", cp_mode, 0); chk("R8 top mem", memrd('hFFFFFF), 'h72);
        // R10 outside the mode
        frame(1, 8'h06); frame(1, 8'h04);
        chk("R10 wel off", wel, 0);
        repeat (4) @(negedge clk);
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule